// File: doc/BRIEF.md
# Transmit Jabber Inhibitor

This block guards a shared bus against a transmitter that never lets go. It watches a transmit-active level and counts time-base ticks of 2.048 ms for as long as that level stays high without a break. When the count reaches an 8-bit programmed limit, the block raises a transmit inhibit. It then holds the inhibit through a fixed lockout of about 3 seconds, which is 1465 ticks, and after that drops it again. The time-base tick comes from an internal divider of the system clock. The divider advances only on cycles where an enable input is high. With the divider ratio set to 1, the enable input itself serves as the tick, so an external 2.048 ms strobe can be used.

Entering the lockout sets a sticky "inhibit started" flag. Leaving it sets a sticky "inhibit ended" flag. Either flag drives the interrupt output. Software clears each flag by writing a one to its bit of the clear input. A limit of zero turns the inhibitor off.

Top module: `jabber_guard`

## Requirements
- R1: After synchronous reset, `tx_inhibit`, `jab_on`, `jab_off` and `irq` are all low.
- R2: With `limit` = N (1 to 255) and `tx_active` held high, the edge that samples the Nth tick raises `tx_inhibit` and `jab_on` together. After N-1 ticks both are still low.
- R3: A cycle with `tx_active` low clears the run count, so a new run needs N further ticks.
- R4: With `limit` = 0 the inhibit never asserts, however long `tx_active` stays high.
- R5: The lockout lasts LOCK_TICKS ticks (default 1465) counted after the entry edge. `tx_inhibit` stays high through LOCK_TICKS-1 of them. The edge that samples the last one drops `tx_inhibit` and sets `jab_off`.
- R6: While locked, `tx_active` has no effect on the lockout. Dropping it does not shorten the lockout.
- R7: The flags are sticky. `status_clr` bit 0 clears `jab_on` and bit 1 clears `jab_off`. Clearing one flag leaves the other unchanged.
- R8: A flag set and a clear of the same flag in the same cycle leave the flag set.
- R9: `irq` is high in exactly the cycles where `jab_on` or `jab_off` is high.
- R10: Once a lockout ends, the run count starts from zero. With `tx_active` still high, a full N ticks pass before the next inhibit.
- R11: With the divider ratio TICK_DIV and `tick_en` held high, tick k falls on clock edge k*TICK_DIV after reset, so inhibit rises after edge N*TICK_DIV.
- R12: The limit compare is "at or beyond". If `limit` is lowered below the ticks already counted, the next tick fires the inhibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Time-base enable; the divider advances only when high |
| tx_active | input | 1 | Transmitter is driving the bus |
| limit | input | LIMIT_W (8) | Run limit in ticks; 0 disables |
| status_clr | input | 2 | Write-one-to-clear: bit 0 for jab_on, bit 1 for jab_off |
| tx_inhibit | output | 1 | Transmission blocked |
| jab_on | output | 1 | Sticky: lockout entered |
| jab_off | output | 1 | Sticky: lockout ended |
| irq | output | 1 | Interrupt, high while any flag is set |

## Verification
The hardest cases to reach are the collisions at the edges of the lockout. One is a tick that fires the inhibit on the same edge as a clear of the entry flag. The other is the final lockout tick arriving together with a clear of the exit flag. The bench sets the divider ratio to 1 and drives each tick as a single-cycle strobe beside the clear pulse, so each collision lands on a chosen edge. A second instance with a free-running divider checks the absolute edge of the first timeout.

// File: rtl/jab_pkg.sv
package jab_pkg;
  typedef enum logic {
    ST_WATCH = 1'b0,
    ST_LOCK  = 1'b1
  } jab_state_e;

  typedef struct packed {
    logic ended;
    logic started;
  } jab_flags_t;
endpackage

// File: rtl/jab_tick_gen.sv
module jab_tick_gen #(
  parameter int TICK_DIV = 256000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  output logic tick
);
  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV == 1) begin : g_direct
      assign tick = tick_en;
    end else begin : g_divider
      localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt <= '0;
        end else if (tick_en) begin
          if (cnt == LAST) cnt <= '0;
          else             cnt <= cnt + 1'b1;
        end
      end

      assign tick = tick_en && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/jab_run_timer.sv
module jab_run_timer #(
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               tx_active,
  input  logic               hold,
  input  logic [LIMIT_W-1:0] limit,
  output logic               fire
);
  localparam int EXT_W = LIMIT_W + 1;

  logic [LIMIT_W-1:0] run_cnt;
  logic [EXT_W-1:0]   next_cnt;
  logic               armed;

  assign armed    = tx_active && !hold && (limit != '0);
  assign next_cnt = {1'b0, run_cnt} + EXT_W'(1);
  assign fire     = armed && tick && (next_cnt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || !armed) begin
      run_cnt <= '0;
    end else if (tick) begin
      if (fire) run_cnt <= '0;
      else      run_cnt <= next_cnt[LIMIT_W-1:0];
    end
  end
endmodule

// File: rtl/jab_lockout.sv
module jab_lockout
  import jab_pkg::*;
#(
  parameter int LOCK_TICKS = 1465
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start,
  output logic locked,
  output logic done
);
  localparam int LK_W = (LOCK_TICKS > 1) ? $clog2(LOCK_TICKS) : 1;
  localparam logic [LK_W-1:0] LK_LAST = LK_W'(LOCK_TICKS - 1);

  jab_state_e       state;
  logic [LK_W-1:0]  lk_cnt;

  assign locked = (state == ST_LOCK);
  assign done   = locked && tick && (lk_cnt == LK_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_WATCH;
      lk_cnt <= '0;
    end else begin
      case (state)
        ST_WATCH: begin
          lk_cnt <= '0;
          if (start) state <= ST_LOCK;
        end
        ST_LOCK: begin
          if (tick) begin
            if (lk_cnt == LK_LAST) begin
              state  <= ST_WATCH;
              lk_cnt <= '0;
            end else begin
              lk_cnt <= lk_cnt + 1'b1;
            end
          end
        end
        default: state <= ST_WATCH;
      endcase
    end
  end
endmodule

// File: rtl/jab_status.sv
module jab_status
  import jab_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       set_on,
  input  logic       set_off,
  input  logic [1:0] clr,
  output logic       jab_on,
  output logic       jab_off,
  output logic       irq
);
  jab_flags_t flags_q, flags_d;

  always_comb begin
    flags_d.started = set_on  | (flags_q.started & ~clr[0]);
    flags_d.ended   = set_off | (flags_q.ended   & ~clr[1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq     <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq     <= flags_d.started | flags_d.ended;
    end
  end

  assign jab_on  = flags_q.started;
  assign jab_off = flags_q.ended;
endmodule

// File: rtl/jabber_guard.sv
module jabber_guard #(
  parameter int LIMIT_W    = 8,
  parameter int TICK_DIV   = 256000,
  parameter int LOCK_TICKS = 1465
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic               tx_active,
  input  logic [LIMIT_W-1:0] limit,
  input  logic [1:0]         status_clr,
  output logic               tx_inhibit,
  output logic               jab_on,
  output logic               jab_off,
  output logic               irq
);
  logic tick;
  logic fire;
  logic locked;
  logic lock_done;

  jab_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .tick    (tick)
  );

  jab_run_timer #(.LIMIT_W(LIMIT_W)) u_run (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .tx_active (tx_active),
    .hold      (locked),
    .limit     (limit),
    .fire      (fire)
  );

  jab_lockout #(.LOCK_TICKS(LOCK_TICKS)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .start  (fire),
    .locked (locked),
    .done   (lock_done)
  );

  jab_status u_stat (
    .clk     (clk),
    .rst     (rst),
    .set_on  (fire),
    .set_off (lock_done),
    .clr     (status_clr),
    .jab_on  (jab_on),
    .jab_off (jab_off),
    .irq     (irq)
  );

  assign tx_inhibit = locked;
endmodule

// File: rtl/jabber_guard_chk.sv
module jabber_guard_chk #(
  parameter int LIMIT_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic               tx_active,
  input logic [LIMIT_W-1:0] limit,
  input logic [1:0]         status_clr,
  input logic               tx_inhibit,
  input logic               jab_on,
  input logic               jab_off,
  input logic               irq
);
  p_entry_sets_flag_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_inhibit) |-> jab_on);

  p_idle_no_fire_r3: assert property (@(posedge clk) disable iff (rst)
    (!tx_active && !tx_inhibit) |=> !tx_inhibit);

  p_disabled_no_fire_r4: assert property (@(posedge clk) disable iff (rst)
    (limit == '0 && !tx_inhibit) |=> !tx_inhibit);

  p_exit_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_inhibit) |-> jab_off);

  p_lock_needs_tick_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_inhibit && !tick) |=> tx_inhibit);

  p_on_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(jab_on) |-> $past(status_clr[0]));

  p_off_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(jab_off) |-> $past(status_clr[1]));

  p_irq_tracks_r9: assert property (@(posedge clk) disable iff (rst)
    irq == (jab_on || jab_off));
endmodule

bind jabber_guard jabber_guard_chk #(.LIMIT_W(LIMIT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .tx_active  (tx_active),
  .limit      (limit),
  .status_clr (status_clr),
  .tx_inhibit (tx_inhibit),
  .jab_on     (jab_on),
  .jab_off    (jab_off),
  .irq        (irq)
);

// File: tb/jabber_guard_bench.sv
module jabber_guard_bench;
  localparam int LK   = 5;
  localparam int DIV2 = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       tx = 1'b0;
  logic [7:0] limit = 8'd0;
  logic [1:0] clr = 2'b00;
  logic       inh, on, off, irq;
  logic       tx2 = 1'b1;
  logic       inh2, on2, off2, irq2;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  jabber_guard #(.LIMIT_W(8), .TICK_DIV(1), .LOCK_TICKS(LK)) u_jabber_guard (
    .clk(clk), .rst(rst), .tick_en(tick_en), .tx_active(tx), .limit(limit),
    .status_clr(clr), .tx_inhibit(inh), .jab_on(on), .jab_off(off), .irq(irq));

  jabber_guard #(.LIMIT_W(8), .TICK_DIV(DIV2), .LOCK_TICKS(LK)) u_jabber_guard_div (
    .clk(clk), .rst(rst), .tick_en(1'b1), .tx_active(tx2), .limit(8'd2),
    .status_clr(2'b00), .tx_inhibit(inh2), .jab_on(on2), .jab_off(off2), .irq(irq2));

  // each row: limit, ticks applied with tx high, expected inhibit and jab_on
  localparam int unsigned TBL [8][3] = '{
    '{1, 1, 1}, '{2, 1, 0}, '{2, 2, 1}, '{5, 4, 0},
    '{5, 5, 1}, '{0, 20, 0}, '{255, 30, 0}, '{3, 3, 1}};

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_tick(input logic [1:0] c);
    @(negedge clk); tick_en = 1'b1; clr = c;
    @(negedge clk); tick_en = 1'b0; clr = 2'b00;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) do_tick(2'b00);
  endtask

  task automatic pulse_clr(input logic [1:0] c);
    @(negedge clk); clr = c;
    @(negedge clk); clr = 2'b00;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; tx = 1'b0; limit = 8'd0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 inhibit", inh, 1'b0);
    chk("R1 jab_on", on, 1'b0);
    chk("R1 jab_off", off, 1'b0);
    chk("R1 irq", irq, 1'b0);
    // R11: divider instance, limit 2, ratio 4 -> fires at edge 8
    repeat (DIV2 * 2 - 1) @(posedge clk);
    @(negedge clk);
    chk("R11 before edge", inh2, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R11 at edge", inh2, 1'b1);
    chk("R11 flag", on2, 1'b1);
    tx2 = 1'b0;

    // R2 / R4: limit sweep
    for (int k = 0; k < 8; k++) begin
      do_reset();
      limit = 8'(TBL[k][0]);
      tx = 1'b1;
      ticks(int'(TBL[k][1]));
      chk((TBL[k][0] == 0) ? "R4 disabled" : "R2 inhibit", inh, logic'(TBL[k][2]));
      chk("R2 jab_on", on, logic'(TBL[k][2]));
      tx = 1'b0;
    end

    // R3: break in activity restarts the run
    do_reset();
    limit = 8'd4; tx = 1'b1;
    ticks(3);
    @(negedge clk); tx = 1'b0;
    @(negedge clk); tx = 1'b1;
    ticks(3);
    chk("R3 restarted run", inh, 1'b0);
    ticks(1);
    chk("R3 full run fires", inh, 1'b1);

    // R5: lockout length with tx held high
    ticks(LK - 1);
    chk("R5 still locked", inh, 1'b1);
    chk("R5 no exit flag yet", off, 1'b0);
    ticks(1);
    chk("R5 released", inh, 1'b0);
    chk("R5 exit flag", off, 1'b1);

    // R10: counting restarts after release
    ticks(3);
    chk("R10 not yet", inh, 1'b0);
    ticks(1);
    chk("R10 refire", inh, 1'b1);

    // R6: dropping tx does not end the lockout
    @(negedge clk); tx = 1'b0;
    ticks(LK - 1);
    chk("R6 held without tx", inh, 1'b1);
    ticks(1);
    chk("R6 released", inh, 1'b0);

    // R7 / R9: W1C of each flag separately
    chk("R9 irq both", irq, 1'b1);
    pulse_clr(2'b01);
    chk("R7 on cleared", on, 1'b0);
    chk("R7 off kept", off, 1'b1);
    chk("R9 irq off only", irq, 1'b1);
    pulse_clr(2'b10);
    chk("R7 off cleared", off, 1'b0);
    chk("R9 irq low", irq, 1'b0);

    // R8: set beats simultaneous clear
    limit = 8'd1; tx = 1'b1;
    do_tick(2'b01);
    chk("R8 inhibit", inh, 1'b1);
    chk("R8 on kept", on, 1'b1);
    pulse_clr(2'b01);
    ticks(LK - 1);
    do_tick(2'b10);
    chk("R8 off kept", off, 1'b1);
    tx = 1'b0;

    // R12: lowered limit fires on next tick
    do_reset();
    limit = 8'd10; tx = 1'b1;
    ticks(4);
    @(negedge clk); limit = 8'd3;
    @(negedge clk);
    chk("R12 no fire without tick", inh, 1'b0);
    ticks(1);
    chk("R12 fire", inh, 1'b1);
    tx = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule